// File: doc/BRIEF.md
# Row-Buffered Byte Write Sequencer

This block sits in front of a small storage array that can only be read or written a full row at a time. Each row holds eight bytes. A CPU-side port offers single-byte reads and writes through a valid/ready handshake. A byte write cannot touch the array directly. The sequencer fetches the whole row into a merge buffer, replaces the one addressed byte, and stores the full row back to the same row. Nothing else may reach the array between the fetch and the store. A byte read fetches the row and returns the selected byte; it does no write-back.

A refresh engine shares the array. When it is enabled, it periodically reads one row and writes the same row back unchanged. It walks the rows in ascending order and wraps at the end. Refresh operations are placed only between CPU sequences, and a waiting CPU request always wins over a waiting refresh. The array command, the row and the requester are visible on observation outputs, so the order of array operations can be judged from outside the block.

Top module: `rowbuf_seq`

## Requirements
- R1: Address bits [2:0] select the byte within a row, and the upper address bits select the row. A byte write changes only the addressed byte; the other seven bytes of that row and all other rows keep their contents.
- R2: An accepted write produces, on consecutive cycles, a row read (`arr_cmd`=1), one cycle with no array command (`arr_cmd`=0), and a row write (`arr_cmd`=2), all on the addressed row with `arr_refresh`=0.
- R3: No other array command, CPU or refresh, appears between the row read and the write-back of a write sequence.
- R4: An accepted read issues a row read in the cycle after acceptance. The selected byte appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the cycle after the row read.
- R5: `req_ready` is high only when no sequence is in progress. It is low in every cycle in which `arr_cmd` is non-zero.
- R6: While `refresh_en` is low, no refresh command is started. A refresh row read happens only if `refresh_en` was high in the cycle before it.
- R7: A refresh is a row read with `arr_refresh`=1, followed in the next cycle by a row write of the same row with `arr_refresh`=1. It leaves every stored byte unchanged.
- R8: Successive refreshes visit rows 0, 1, 2 and so on in ascending order and wrap from the last row back to row 0.
- R9: When a request is valid at a sequence boundary, the next array command is that request's CPU row read, even if a refresh is pending.
- R10: After reset, `req_ready` is 1, `arr_cmd` is 0, every stored byte is 0 and the refresh row counter starts at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | BYTE_W | Write byte |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | BYTE_W | Read byte |
| refresh_en | input | 1 | Allows refresh operations |
| arr_cmd | output | 2 | Array command: 0 none, 1 row read, 2 row write |
| arr_row | output | ADDR_W-3 | Row of the current array command |
| arr_refresh | output | 1 | Current array command belongs to the refresh engine |

## Verification
A CPU request arriving at a sequence boundary and a refresh that has come due can meet in the same idle cycle. The bench provokes this by keeping refresh enabled while it issues back-to-back requests, with `req_valid` raised again as soon as each sequence ends. A monitor then judges every boundary. When a request was accepted, the next array command must be its CPU row read. Refresh commands must appear only in request gaps, as read/write pairs on the expected ascending row, and never inside a write sequence. Byte-level reference contents are then compared over the whole address space to show that neither neighbouring bytes nor refreshed rows were disturbed.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_RD   = 2'd1,
      CMD_WR   = 2'd2
   } arr_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE, S_CRD, S_CMRG, S_CWB, S_CRET, S_RRD, S_RWB
   } seq_state_e;
endpackage

// File: rtl/rbw_array.sv
module rbw_array
   import rbw_pkg::*;
#(
   parameter int ROWS   = 8,
   parameter int ROW_W  = 64,
   parameter int ROW_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  arr_cmd_e          cmd,
   input  logic [ROW_AW-1:0] row,
   input  logic [ROW_W-1:0]  wdata,
   output logic [ROW_W-1:0]  rdata
);
   logic [ROW_W-1:0] store_q [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) store_q[r] <= '0;
         rdata <= '0;
      end else begin
         if (cmd == CMD_RD) rdata <= store_q[row];
         if (cmd == CMD_WR) store_q[row] <= wdata;
      end
   end
endmodule

// File: rtl/rbw_merge.sv
module rbw_merge #(
   parameter int LANES  = 8,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [LANES*BYTE_W-1:0] row_in,
   input  logic [SEL_W-1:0]        sel,
   input  logic [BYTE_W-1:0]       byte_in,
   output logic [LANES*BYTE_W-1:0] row_out,
   output logic [BYTE_W-1:0]       byte_out
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign row_out[g*BYTE_W +: BYTE_W] =
         (sel == SEL_W'(g)) ? byte_in : row_in[g*BYTE_W +: BYTE_W];
   end

   assign byte_out = row_in[sel*BYTE_W +: BYTE_W];
endmodule

// File: rtl/rbw_refresh.sv
module rbw_refresh #(
   parameter int ROW_AW = 3,
   parameter int GAP    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic              done,
   output logic              pending,
   output logic [ROW_AW-1:0] row
);
   localparam int TW = (GAP > 2) ? $clog2(GAP) : 1;
   logic [TW-1:0] timer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer_q <= '0;
         pending <= 1'b0;
         row     <= '0;
      end else begin
         if (start) pending <= 1'b0;
         else if (en && !pending) begin
            if (timer_q == TW'(GAP - 1)) begin
               timer_q <= '0;
               pending <= 1'b1;
            end else begin
               timer_q <= timer_q + 1'b1;
            end
         end
         if (done) row <= row + 1'b1;
      end
   end
endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
   import rbw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int BYTE_W      = 8,
   parameter int ROW_BYTES   = 8,
   parameter int REFRESH_GAP = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [BYTE_W-1:0]    req_wdata,
   output logic                 req_ready,
   output logic                 rsp_valid,
   output logic [BYTE_W-1:0]    rsp_rdata,
   input  logic                 refresh_en,
   output logic [1:0]           arr_cmd,
   output logic [ADDR_W-4:0]    arr_row,
   output logic                 arr_refresh
);
   localparam int SEL_W  = $clog2(ROW_BYTES);
   localparam int ROW_AW = ADDR_W - SEL_W;
   localparam int ROWS   = 2 ** ROW_AW;
   localparam int ROW_W  = ROW_BYTES * BYTE_W;

   if (ROW_BYTES != 8) begin : g_bad_row
      $error("rowbuf_seq: ROW_BYTES must be 8 (three byte-select bits)");
   end
   if (ADDR_W <= SEL_W || ADDR_W > 12) begin : g_bad_addr
      $error("rowbuf_seq: ADDR_W out of range");
   end
   if (REFRESH_GAP < 2) begin : g_bad_gap
      $error("rowbuf_seq: REFRESH_GAP must be at least 2");
   end

   seq_state_e        state_q, state_d;
   logic [ROW_AW-1:0] a_row;
   logic [SEL_W-1:0]  a_sel;
   logic [BYTE_W-1:0] a_wdata;
   logic              a_write;
   logic [ROW_W-1:0]  mbuf_q, rd_row, merged, wr_row;
   logic [BYTE_W-1:0] sel_byte;
   logic [ROW_AW-1:0] ref_row, cmd_row;
   logic              ref_pending, ref_start, ref_done, accept;
   arr_cmd_e          cmd;

   assign req_ready = (state_q == S_IDLE);
   assign accept    = req_ready && req_valid;
   assign ref_start = req_ready && !req_valid && ref_pending && refresh_en;
   assign ref_done  = (state_q == S_RWB);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE: if (accept) state_d = S_CRD;
                 else if (ref_start) state_d = S_RRD;
         S_CRD:  state_d = a_write ? S_CMRG : S_CRET;
         S_CMRG: state_d = S_CWB;
         S_CWB:  state_d = S_IDLE;
         S_CRET: state_d = S_IDLE;
         S_RRD:  state_d = S_RWB;
         S_RWB:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_q)
         S_CRD, S_RRD: cmd = CMD_RD;
         S_CWB, S_RWB: cmd = CMD_WR;
         default:      cmd = CMD_NONE;
      endcase
   end

   assign arr_refresh = (state_q == S_RRD) || (state_q == S_RWB);
   assign cmd_row     = arr_refresh ? ref_row : a_row;
   assign wr_row      = arr_refresh ? rd_row : mbuf_q;
   assign arr_cmd     = cmd;
   assign arr_row     = cmd_row;
   assign rsp_valid   = (state_q == S_CRET);
   assign rsp_rdata   = sel_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         a_row   <= '0;
         a_sel   <= '0;
         a_wdata <= '0;
         a_write <= 1'b0;
         mbuf_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            a_row   <= req_addr[ADDR_W-1:SEL_W];
            a_sel   <= req_addr[SEL_W-1:0];
            a_wdata <= req_wdata;
            a_write <= req_write;
         end
         if (state_q == S_CMRG) mbuf_q <= merged;
      end
   end

   rbw_array #(.ROWS(ROWS), .ROW_W(ROW_W), .ROW_AW(ROW_AW)) u_array (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .row(cmd_row),
      .wdata(wr_row), .rdata(rd_row)
   );

   rbw_merge #(.LANES(ROW_BYTES), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_merge (
      .row_in(rd_row), .sel(a_sel), .byte_in(a_wdata),
      .row_out(merged), .byte_out(sel_byte)
   );

   rbw_refresh #(.ROW_AW(ROW_AW), .GAP(REFRESH_GAP)) u_refresh (
      .clk(clk), .rst_n(rst_n), .en(refresh_en), .start(ref_start),
      .done(ref_done), .pending(ref_pending), .row(ref_row)
   );
endmodule

// File: rtl/rbw_checker.sv
module rbw_checker #(
   parameter int ROW_AW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              refresh_en,
   input logic [1:0]        arr_cmd,
   input logic [ROW_AW-1:0] arr_row,
   input logic              arr_refresh,
   input logic              cur_write
);
   a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd != 2'd0) |-> !req_ready);

   a_r9_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (arr_cmd == 2'd1 && !arr_refresh));

   a_r3_no_gap_op: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd == 2'd1 && !arr_refresh && cur_write) |=> (arr_cmd == 2'd0));

   a_r2_writeback_row: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd == 2'd1 && !arr_refresh && cur_write) |=>
         ##1 (arr_cmd == 2'd2 && !arr_refresh && arr_row == $past(arr_row, 2)));

   a_r6_refresh_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd == 2'd1 && arr_refresh) |-> $past(refresh_en));

   a_r7_restore_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_cmd == 2'd1 && arr_refresh) |=>
         (arr_cmd == 2'd2 && arr_refresh && arr_row == $past(arr_row)));
endmodule

bind rowbuf_seq rbw_checker #(.ROW_AW(ROW_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .refresh_en(refresh_en), .arr_cmd(arr_cmd), .arr_row(arr_row),
   .arr_refresh(arr_refresh), .cur_write(a_write)
);

// File: tb/rowbuf_seq_test.sv
module rowbuf_seq_test;
   localparam int AW = 6;
   localparam int NB = 2 ** AW;
   localparam int NR = NB / 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, refresh_en = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic req_ready, rsp_valid, arr_refresh;
   logic [7:0] rsp_rdata;
   logic [1:0] arr_cmd;
   logic [AW-4:0] arr_row;

   int checks = 0, fails = 0, cycles = 0;
   logic [7:0] ref_mem [NB];
   logic [7:0] got;

   int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0;
   int ref_ops = 0;

   always #2 clk = ~clk;

   rowbuf_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .refresh_en(refresh_en),
      .arr_cmd(arr_cmd), .arr_row(arr_row), .arr_refresh(arr_refresh)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Port monitor, sampled at the falling edge
   logic prev_acc = 0, prev_wr = 0, prev_en = 0;
   logic [AW-4:0] prev_row = '0, cpu_row = '0, ref_exp = '0;
   int cpu_stage = 0, ref_stage = 0;
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (arr_cmd != 0 && req_ready) v_r5++;
         if (cpu_stage == 1) begin
            if (!(arr_cmd == 1 && !arr_refresh && arr_row == cpu_row)) v_r9++;
            cpu_stage = prev_wr ? 2 : 0;
         end else if (cpu_stage == 2) begin
            if (arr_cmd != 0) v_r3++;
            cpu_stage = 3;
         end else if (cpu_stage == 3) begin
            if (!(arr_cmd == 2 && !arr_refresh && arr_row == cpu_row)) v_r2++;
            cpu_stage = 0;
         end
         if (ref_stage == 1) begin
            if (!(arr_cmd == 2 && arr_refresh && arr_row == ref_exp)) v_r7++;
            ref_stage = 0;
            ref_exp = ref_exp + 1'b1;
         end else if (arr_cmd == 1 && arr_refresh) begin
            if (!prev_en) v_r6++;
            if (arr_row != ref_exp) v_r8++;
            ref_stage = 1;
            ref_ops++;
         end
         if (req_valid && req_ready) begin
            cpu_stage = 1;
            prev_wr = req_write;
            cpu_row = req_addr[AW-1:3];
         end
      end
      prev_en = refresh_en;
   end

   task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
      int lat;
      rd = '0;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         lat = 1;
         while (!rsp_valid && lat < 10) begin
            @(negedge clk); lat++;
         end
         if (lat != 2) v_r4++;
         rd = rsp_rdata;
         @(negedge clk);
         if (rsp_valid) v_r4++;
      end
   endtask

   function automatic logic [7:0] pat1(input int a);
      return 8'((a * 29 + 7) & 255);
   endfunction
   function automatic logic [7:0] pat2(input int a);
      return 8'((a * 13 + 90) & 255) ^ 8'hC3;
   endfunction

   task automatic sweep_read(input string req);
      for (int a = 0; a < NB; a++) begin
         do_req(1'b0, AW'(a), 8'h00, got);
         check(req, int'(got), int'(ref_mem[a]));
      end
   endtask

   initial begin
      for (int a = 0; a < NB; a++) ref_mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 ready", int'(req_ready), 1);
      check("R10 cmd", int'(arr_cmd), 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_req(1'b0, AW'(13), 8'h00, got);
      check("R10 mem zero", int'(got), 0);

      // R1/R2: fill every byte with refresh off
      for (int a = 0; a < NB; a++) begin
         do_req(1'b1, AW'(a), pat1(a), got);
         ref_mem[a] = pat1(a);
      end
      sweep_read("R1 fill");
      check("R6 no refresh while disabled", ref_ops, 0);

      // R1/R9: rewrite odd bytes with refresh on
      refresh_en = 1'b1;
      for (int a = 1; a < NB; a += 2) begin
         do_req(1'b1, AW'(a), pat2(a), got);
         ref_mem[a] = pat2(a);
      end
      sweep_read("R1 neighbours");

      // R7/R8: idle while refresh walks all rows twice
      repeat (NR * 2 * 20 + 50) @(negedge clk);
      check("R8 refresh ran over all rows", int'(ref_ops >= 2 * NR), 1);
      sweep_read("R7 refresh preserves");

      refresh_en = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 write sequence", v_r2, 0);
      check("R3 atomic sequence", v_r3, 0);
      check("R4 read latency", v_r4, 0);
      check("R5 ready low when busy", v_r5, 0);
      check("R6 refresh gated", v_r6, 0);
      check("R7 refresh pair", v_r7, 0);
      check("R8 refresh order", v_r8, 0);
      check("R9 cpu priority", v_r9, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule